// File: doc/BRIEF.md
# SMBus Host Controller Register File

This block is the byte-wide programming front end of an SMBus host controller. Software reaches it through a simple strobe interface: one access per cycle, with a valid flag, a write flag, an offset and a write byte. The block decodes seven registers: status, control, command, target address, two data bytes and a port into a 32-entry block buffer. It keeps their contents and returns read data one clock after the access.

A separate transaction engine does the bus signalling. It sees control, command, address and both data bytes directly on output ports. It also reads the block buffer through its own index port. Writing the control register with bit 6 set sends the engine a one-clock go pulse. The engine reports back with a completion strobe, an error strobe and load strobes for the two data bytes. These update the status and data registers.

The block buffer is reached through a single window offset. One index steps through the buffer on every access to that offset. Software rewinds the index by reading control or by writing status.

Top module: `smbus_hostregs`

## Requirements
- R1: After reset every register reads 0, the block buffer holds zeros, the buffer index is 0 and the go pulse is low.
- R2: Offsets other than 0x00, 0x02, 0x03, 0x04, 0x05, 0x06 and 0x07 read as 0. Writes to them change no register.
- R3: Command (0x03), target address (0x04), data0 (0x05) and data1 (0x06) store each written byte and read it back. Their values appear on the engine ports from the cycle after the write.
- R4: A write to control (0x02) stores all 8 bits, which are visible on `eng_ctl`. A read of control returns only bits 4:0, with bits 7:5 read as 0.
- R5: A control write with bit 6 set raises `go_pulse` for exactly the one cycle after the write. A control write with bit 6 clear raises no pulse.
- R6: A write to status (0x00) clears each status bit written as 1 and leaves the other bits unchanged. The status bits are: bit0 busy, bit1 interrupt, bit2 device error, bit3 bus error, bit4 failed, bit5 alert, bit6 in-use, bit7 byte done.
- R7: `eng_done` sets status bits 7 and 1, and `eng_err` sets status bit 2. When such a strobe and a host status write fall in the same cycle, the set wins over the clear.
- R8: Each read or write at offset 0x07 uses the current buffer entry and then advances the index. After entry 31 the index wraps to 0.
- R9: A read of control or a write of status returns the buffer index to 0.
- R10: `eng_ld0` / `eng_ld1` load `eng_rd0` / `eng_rd1` into data0 / data1. In a cycle where a host write to the same register also occurs, the engine value is kept.
- R11: `eng_blk_data` shows, in the same cycle, the buffer entry selected by `eng_blk_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register offset |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, valid the cycle after a read access |
| go_pulse | output | 1 | One-cycle transaction start |
| eng_ctl | output | 8 | Stored control byte |
| eng_cmd | output | 8 | Command byte |
| eng_taddr | output | 8 | Target address byte |
| eng_dat0 | output | 8 | Data0 byte |
| eng_dat1 | output | 8 | Data1 byte |
| eng_blk_idx | input | IDX_W | Engine buffer index |
| eng_blk_data | output | 8 | Buffer entry at `eng_blk_idx` |
| eng_done | input | 1 | Transaction completed |
| eng_err | input | 1 | Transaction failed |
| eng_ld0 | input | 1 | Load data0 from engine |
| eng_ld1 | input | 1 | Load data1 from engine |
| eng_rd0 | input | 8 | Engine result low byte |
| eng_rd1 | input | 8 | Engine result high byte |

## Verification
A host access or engine strobe applied in a cycle takes effect at the next rising edge.
- Read data, the go pulse and the engine-side register ports are checked one cycle after the access.
- A status change from an engine strobe is checked with a status read issued after the strobe, so its result lands two cycles after the strobe.
- `eng_blk_data` is combinational, so it is checked in the same cycle the index is set.

The bench drives on the falling edge and samples on the next falling edge. Every check therefore falls mid-cycle, after the edge that updates the result.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
   localparam int NREG = 7;

   typedef enum logic [2:0] {
      RS_STAT = 3'd0,
      RS_CTRL = 3'd1,
      RS_CMD  = 3'd2,
      RS_TADR = 3'd3,
      RS_DAT0 = 3'd4,
      RS_DAT1 = 3'd5,
      RS_BLK  = 3'd6
   } reg_sel_e;

   localparam logic [7:0] REG_OFS [NREG] = '{8'h00, 8'h02, 8'h03, 8'h04,
                                             8'h05, 8'h06, 8'h07};

   localparam int ST_BUSY   = 0;
   localparam int ST_IRQ    = 1;
   localparam int ST_DEVERR = 2;
   localparam int ST_BUSERR = 3;
   localparam int ST_FAIL   = 4;
   localparam int ST_ALERT  = 5;
   localparam int ST_INUSE  = 6;
   localparam int ST_BDONE  = 7;

   localparam int CTL_GO_BIT   = 6;
   localparam int CTL_VIS_BITS = 5;
endpackage

// File: rtl/smbh_decode.sv
module smbh_decode
   import smbh_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NREG-1:0]   hit
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("smbh_decode: ADDR_W must be at least 3");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_hit
      assign hit[i] = (addr == ADDR_W'(REG_OFS[i]));
   end
endmodule

// File: rtl/smbh_status.sv
module smbh_status
   import smbh_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] clr_mask,
   input  logic              eng_done,
   input  logic              eng_err,
   output logic [DATA_W-1:0] sts_q
);
   logic [DATA_W-1:0] set_mask;

   always_comb begin
      set_mask = '0;
      set_mask[ST_BDONE]  = eng_done;
      set_mask[ST_IRQ]    = eng_done;
      set_mask[ST_DEVERR] = eng_err;
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            sts_q[b] <= 1'b0;
         else if (set_mask[b])
            sts_q[b] <= 1'b1;
         else if (clr_we && clr_mask[b])
            sts_q[b] <= 1'b0;
      end
   end

   p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> (sts_q[ST_BDONE] && sts_q[ST_IRQ]));
   p_err_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_err |=> sts_q[ST_DEVERR]);
   p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !eng_done && !eng_err) |=> ((sts_q & $past(clr_mask)) == '0));
endmodule

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_clr,
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [IDX_W-1:0]  eng_idx,
   output logic [DATA_W-1:0] eng_data
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("smbh_blkbuf: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (idx_clr) begin
         idx_q <= '0;
      end else if (acc_en) begin
         idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (acc_en && acc_we) begin
         mem[idx_q] <= wdata;
      end
   end

   assign rdata    = mem[idx_q];
   assign eng_data = (int'(eng_idx) < DEPTH) ? mem[eng_idx] : '0;

   p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx_q) < DEPTH);
   p_idx_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !idx_clr && idx_q == LAST) |=> (idx_q == '0));
   p_idx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      idx_clr |=> (idx_q == '0));
endmodule

// File: rtl/smbus_hostregs.sv
module smbus_hostregs
   import smbh_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int BLK_DEPTH = 32,
   localparam int IDX_W    = $clog2(BLK_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              go_pulse,
   output logic [DATA_W-1:0] eng_ctl,
   output logic [DATA_W-1:0] eng_cmd,
   output logic [DATA_W-1:0] eng_taddr,
   output logic [DATA_W-1:0] eng_dat0,
   output logic [DATA_W-1:0] eng_dat1,
   input  logic [IDX_W-1:0]  eng_blk_idx,
   output logic [DATA_W-1:0] eng_blk_data,
   input  logic              eng_done,
   input  logic              eng_err,
   input  logic              eng_ld0,
   input  logic              eng_ld1,
   input  logic [DATA_W-1:0] eng_rd0,
   input  logic [DATA_W-1:0] eng_rd1
);
   localparam logic [DATA_W-1:0] CTL_RD_MASK = DATA_W'((1 << CTL_VIS_BITS) - 1);

   if (DATA_W != 8) begin : g_bad_width
      $error("smbus_hostregs: registers are one byte wide");
   end
   if (CTL_GO_BIT >= DATA_W) begin : g_bad_go
      $error("smbus_hostregs: go bit outside control byte");
   end

   logic [NREG-1:0]   hit;
   logic [NREG-1:0]   wr_sel;
   logic [NREG-1:0]   rd_sel;
   logic              wr_any;
   logic              rd_any;
   logic [DATA_W-1:0] ctl_q, cmd_q, tadr_q, dat0_q, dat1_q;
   logic [DATA_W-1:0] sts_q;
   logic [DATA_W-1:0] blk_rdata;
   logic [DATA_W-1:0] rd_mux;
   logic              go_q;
   logic [DATA_W-1:0] rdata_q;

   assign wr_any = acc_valid && acc_write;
   assign rd_any = acc_valid && !acc_write;
   assign wr_sel = hit & {NREG{wr_any}};
   assign rd_sel = hit & {NREG{rd_any}};

   smbh_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (acc_addr),
      .hit  (hit)
   );

   smbh_status #(.DATA_W(DATA_W)) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_we   (wr_sel[RS_STAT]),
      .clr_mask (acc_wdata),
      .eng_done (eng_done),
      .eng_err  (eng_err),
      .sts_q    (sts_q)
   );

   smbh_blkbuf #(.DATA_W(DATA_W), .DEPTH(BLK_DEPTH)) u_blk (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_clr  (wr_sel[RS_STAT] || rd_sel[RS_CTRL]),
      .acc_en   (acc_valid && hit[RS_BLK]),
      .acc_we   (acc_write),
      .wdata    (acc_wdata),
      .rdata    (blk_rdata),
      .eng_idx  (eng_blk_idx),
      .eng_data (eng_blk_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         cmd_q  <= '0;
         tadr_q <= '0;
         go_q   <= 1'b0;
      end else begin
         if (wr_sel[RS_CTRL]) ctl_q  <= acc_wdata;
         if (wr_sel[RS_CMD])  cmd_q  <= acc_wdata;
         if (wr_sel[RS_TADR]) tadr_q <= acc_wdata;
         go_q <= wr_sel[RS_CTRL] && acc_wdata[CTL_GO_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dat0_q <= '0;
         dat1_q <= '0;
      end else begin
         if (eng_ld0)              dat0_q <= eng_rd0;
         else if (wr_sel[RS_DAT0]) dat0_q <= acc_wdata;
         if (eng_ld1)              dat1_q <= eng_rd1;
         else if (wr_sel[RS_DAT1]) dat1_q <= acc_wdata;
      end
   end

   always_comb begin
      rd_mux = '0;
      unique case (1'b1)
         hit[RS_STAT]: rd_mux = sts_q;
         hit[RS_CTRL]: rd_mux = ctl_q & CTL_RD_MASK;
         hit[RS_CMD]:  rd_mux = cmd_q;
         hit[RS_TADR]: rd_mux = tadr_q;
         hit[RS_DAT0]: rd_mux = dat0_q;
         hit[RS_DAT1]: rd_mux = dat1_q;
         hit[RS_BLK]:  rd_mux = blk_rdata;
         default:      rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rd_any ? rd_mux : '0;
   end

   assign acc_rdata = rdata_q;
   assign go_pulse  = go_q;
   assign eng_ctl   = ctl_q;
   assign eng_cmd   = cmd_q;
   assign eng_taddr = tadr_q;
   assign eng_dat0  = dat0_q;
   assign eng_dat1  = dat1_q;

   p_go_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      go_pulse |-> $past(acc_valid && acc_write && hit[RS_CTRL] && acc_wdata[CTL_GO_BIT]));
   p_ctl_read_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && hit[RS_CTRL]) |=> (acc_rdata[DATA_W-1:CTL_VIS_BITS] == '0));
   p_eng_wins0_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_ld0 |=> (eng_dat0 == $past(eng_rd0)));
   p_eng_wins1_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_ld1 |=> (eng_dat1 == $past(eng_rd1)));
   p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && hit == '0) |=> (acc_rdata == '0));
endmodule

// File: tb/sim_smbus_hostregs.sv
module sim_smbus_hostregs;
   localparam int AW = 6;
   localparam int IW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0, acc_write = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [7:0]    acc_wdata = '0;
   logic [7:0]    acc_rdata;
   logic          go_pulse;
   logic [7:0]    eng_ctl, eng_cmd, eng_taddr, eng_dat0, eng_dat1, eng_blk_data;
   logic [IW-1:0] eng_blk_idx = '0;
   logic          eng_done = 1'b0, eng_err = 1'b0, eng_ld0 = 1'b0, eng_ld1 = 1'b0;
   logic [7:0]    eng_rd0 = '0, eng_rd1 = '0;
   int            n_run = 0;
   int            n_fail = 0;
   bit            finished = 1'b0;

   always #4 clk = ~clk;

   smbus_hostregs u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .go_pulse(go_pulse), .eng_ctl(eng_ctl), .eng_cmd(eng_cmd),
      .eng_taddr(eng_taddr), .eng_dat0(eng_dat0), .eng_dat1(eng_dat1),
      .eng_blk_idx(eng_blk_idx), .eng_blk_data(eng_blk_data),
      .eng_done(eng_done), .eng_err(eng_err), .eng_ld0(eng_ld0),
      .eng_ld1(eng_ld1), .eng_rd0(eng_rd0), .eng_rd1(eng_rd1)
   );

   // {write, offset[5:0], wdata[7:0], expected[7:0]}
   localparam int NV = 16;
   localparam logic [22:0] VEC [NV] = '{
      {1'b1, 6'h03, 8'hA5, 8'h00},  // R3
      {1'b1, 6'h04, 8'h3C, 8'h00},
      {1'b1, 6'h05, 8'h11, 8'h00},
      {1'b1, 6'h06, 8'h22, 8'h00},
      {1'b0, 6'h03, 8'h00, 8'hA5},
      {1'b0, 6'h04, 8'h00, 8'h3C},
      {1'b0, 6'h05, 8'h00, 8'h11},
      {1'b0, 6'h06, 8'h00, 8'h22},
      {1'b1, 6'h02, 8'h9F, 8'h00},  // R4
      {1'b0, 6'h02, 8'h00, 8'h1F},
      {1'b1, 6'h01, 8'h77, 8'h00},  // R2
      {1'b0, 6'h01, 8'h00, 8'h00},
      {1'b1, 6'h08, 8'h55, 8'h00},
      {1'b0, 6'h08, 8'h00, 8'h00},
      {1'b0, 6'h3F, 8'h00, 8'h00},
      {1'b0, 6'h03, 8'h00, 8'hA5}
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
      @(negedge clk);
      acc_valid = 1'b0;
      check(tag, acc_rdata, exp);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 go", {7'd0, go_pulse}, 8'h00);
      rd(6'h00, 8'h00, "R1 status");
      rd(6'h05, 8'h00, "R1 data0");
      rd(6'h07, 8'h00, "R1 block");
      rd(6'h02, 8'h00, "R1 control");

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][22]) wr(VEC[i][21:16], VEC[i][15:8]);
         else            rd(VEC[i][21:16], VEC[i][7:0], "R2/R3/R4 table");
      end
      check("R3 eng_cmd", eng_cmd, 8'hA5);
      check("R3 eng_taddr", eng_taddr, 8'h3C);
      check("R3 eng_dat1", eng_dat1, 8'h22);
      check("R4 eng_ctl", eng_ctl, 8'h9F);

      // R5: go pulse
      wr(6'h02, 8'h9F);
      check("R5 no pulse", {7'd0, go_pulse}, 8'h00);
      wr(6'h02, 8'h40);
      check("R5 pulse", {7'd0, go_pulse}, 8'h01);
      @(negedge clk);
      check("R5 pulse width", {7'd0, go_pulse}, 8'h00);

      // R7 / R6: status set and clear
      eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
      rd(6'h00, 8'h82, "R7 done");
      wr(6'h00, 8'h02);
      rd(6'h00, 8'h80, "R6 w1c");
      eng_err = 1'b1; @(negedge clk); eng_err = 1'b0;
      rd(6'h00, 8'h84, "R7 err");
      eng_done = 1'b1; wr(6'h00, 8'hFF); eng_done = 1'b0;
      rd(6'h00, 8'h82, "R7 set beats clear");

      // R8: fill 33 entries, last wraps to entry 0
      for (int i = 0; i < 33; i++) wr(6'h07, (i == 32) ? 8'h60 : 8'(8'h40 + i));
      rd(6'h02, 8'h00, "R9 ctl read");
      rd(6'h07, 8'h60, "R8 wrap write");
      for (int i = 1; i < 32; i++) rd(6'h07, 8'(8'h40 + i), "R8 block read");
      rd(6'h07, 8'h60, "R8 wrap read");
      rd(6'h07, 8'h41, "R8 after wrap");
      wr(6'h00, 8'h00);
      rd(6'h07, 8'h60, "R9 status write");

      // R11: engine-side buffer port
      eng_blk_idx = 5'd5; #1;
      check("R11 eng_blk", eng_blk_data, 8'h45);
      eng_blk_idx = 5'd31; #1;
      check("R11 eng_blk last", eng_blk_data, 8'h5F);

      // R10: engine load beats host write
      eng_ld0 = 1'b1; eng_rd0 = 8'h99; wr(6'h05, 8'h11); eng_ld0 = 1'b0;
      rd(6'h05, 8'h99, "R10 data0 priority");
      eng_ld1 = 1'b1; eng_rd1 = 8'h7E; @(negedge clk); eng_ld1 = 1'b0;
      rd(6'h06, 8'h7E, "R10 data1 load");
      check("R10 eng_dat0", eng_dat0, 8'h99);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule